// File: doc/BRIEF.md
# System Register Access Gate

This block guards a single 64-bit auxiliary control register inside a processor core. Each cycle it may receive one system-register move request, either a read or a write. It first compares the request's encoding fields against the register's selector. It then uses the current exception level and the hypervisor control inputs to resolve the access to exactly one of four outcomes:

- an undefined-instruction exception;
- a trap to the hypervisor, with syndrome class 0x18;
- a redirect to a memory slot at a fixed offset from a base address;
- a direct read or write of the register.

Two 32-bit legacy-mode views of the same storage are also provided. One covers the low word and the other covers the high word.

The result appears one cycle after the request as a short response pulse. It carries a result code, the read data, the syndrome class, and the redirect address and write data. The core's exception logic consumes the response, and so does the memory path that services redirected accesses. A request whose selector does not match is flagged as unclaimed and changes nothing, so another decoder can take it.

Top module: `sysreg_gate`

## Requirements
- R1: A non-legacy request matches only when op0=2'b11, op1=3'b000, crn=4'b0001, crm=4'b0000 and op2=3'b001. Any other request raises rsp_nomatch, reports kind 0, and leaves the register unchanged.
- R2: A matched or legacy request with cur_el=0 reports kind UNDEF (2'd1) and does not update the register.
- R3: At cur_el=1, with el2_en=1, el2_64=1 and trap_acr=1, the request reports kind TRAP (2'd2) with rsp_ec=6'h18 and does not update the register. rsp_ec is 0 for every other kind.
- R4: At cur_el=1, with el2_en=1, el2_64=1, trap_acr=0 and nv_bits matching 1x1 (bit 2 and bit 0 set), the request reports kind REDIR (2'd3). rsp_redir_addr then equals slot_base+0x118, rsp_wdata carries the write data, and the register is unchanged.
- R5: In all other cases at cur_el=1, and always at cur_el=2 or 3, the request reports kind DIRECT (2'd0). A read returns the register value in rsp_rdata and a write stores wdata.
- R6: At cur_el=1, if el2_en=0 or el2_64=0, trap_acr and nv_bits have no effect and the access is direct.
- R7: A legacy request (req_legacy=1) needs no selector match. It is UNDEF at cur_el=0 and DIRECT at every other level. A read with req_half=0 returns bits [31:0] and with req_half=1 returns bits [63:32], zero-extended.
- R8: A legacy write updates only the selected 32-bit half and leaves the other half unchanged.
- R9: The response fields are valid for exactly one cycle, one clock after the request, with rsp_valid=1. Non-read outcomes return rsp_rdata=0.
- R10: When both the trap condition and the redirect condition hold, the trap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (response only) |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write move, 0 = read move |
| req_legacy | input | 1 | 1 = 32-bit legacy view access |
| req_half | input | 1 | Legacy view: 0 low word, 1 high word |
| op0 | input | 2 | Encoding field |
| op1 | input | 3 | Encoding field |
| crn | input | 4 | Encoding field |
| crm | input | 4 | Encoding field |
| op2 | input | 3 | Encoding field |
| wdata | input | 64 | Write data (legacy uses [31:0]) |
| cur_el | input | 2 | Current exception level |
| el2_en | input | 1 | Hypervisor level enabled |
| el2_64 | input | 1 | Hypervisor level in 64-bit state |
| trap_acr | input | 1 | Hypervisor trap-auxiliary-control bit |
| nv_bits | input | 3 | Nested virtualization bits {NV2,NV1,NV} |
| slot_base | input | ADDR_W | Base address of the redirect area |
| rsp_valid | output | 1 | Response pulse |
| rsp_kind | output | 2 | 0 DIRECT, 1 UNDEF, 2 TRAP, 3 REDIR |
| rsp_nomatch | output | 1 | Request not claimed |
| rsp_write | output | 1 | Direction of the resolved request |
| rsp_rdata | output | 64 | Read data |
| rsp_ec | output | 6 | Trap syndrome class |
| rsp_redir_addr | output | ADDR_W | Redirect slot address |
| rsp_wdata | output | 64 | Write data for a redirected write |

## Verification
The bench goes after the ordering corners:

- It sets trap and redirect conditions together at EL1. A design that checked the redirect first would report REDIR instead of TRAP.
- It sets trap and redirect bits with the hypervisor level disabled or in 32-bit state. A design that ignored the gating would trap or redirect where a direct access is due.
- It sets nv_bits to 1x0 and 0x1. A design that decoded the pattern loosely would redirect on them.
- It writes each legacy half and reads back through the other view and the full view. A half-write that spilled over would corrupt the other word.
- It sends a write with a selector that is wrong in a single field, and a write from EL0. Either one wrongly landing in the register shows up in the next full read.

// File: rtl/sysreg_gate.sv
module sysreg_gate #(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 48,
  parameter int SLOT_OFF = 'h118,
  parameter int EC_W     = 6,
  parameter logic [5:0] TRAP_EC = 6'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_legacy,
  input  logic              req_half,
  input  logic [1:0]        op0,
  input  logic [2:0]        op1,
  input  logic [3:0]        crn,
  input  logic [3:0]        crm,
  input  logic [2:0]        op2,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        cur_el,
  input  logic              el2_en,
  input  logic              el2_64,
  input  logic              trap_acr,
  input  logic [2:0]        nv_bits,
  input  logic [ADDR_W-1:0] slot_base,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic              rsp_nomatch,
  output logic              rsp_write,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [EC_W-1:0]   rsp_ec,
  output logic [ADDR_W-1:0] rsp_redir_addr,
  output logic [DATA_W-1:0] rsp_wdata
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [1:0] K_DIRECT = 2'd0, K_UNDEF = 2'd1, K_TRAP = 2'd2, K_REDIR = 2'd3;

  logic [DATA_W-1:0] ctl_q;
  logic [1:0]        kind;

  wire sel_ok = (op0 == 2'b11) && (op1 == 3'b000) && (crn == 4'b0001) &&
                (crm == 4'b0000) && (op2 == 3'b001);
  wire claimed = req_valid && (req_legacy || sel_ok);
  wire el2_live = el2_en && el2_64;
  wire at_el1 = (cur_el == 2'd1);
  wire nv_hit = nv_bits[2] && nv_bits[0];

  always_comb begin
    if (cur_el == 2'd0)                        kind = K_UNDEF;
    else if (req_legacy)                       kind = K_DIRECT;
    else if (at_el1 && el2_live && trap_acr)   kind = K_TRAP;
    else if (at_el1 && el2_live && nv_hit)     kind = K_REDIR;
    else                                       kind = K_DIRECT;
  end

  wire do_write = claimed && req_write && (kind == K_DIRECT);
  wire do_read  = claimed && !req_write && (kind == K_DIRECT);

  always_ff @(posedge clk) begin
    if (do_write) begin
      if (!req_legacy)   ctl_q <= wdata;
      else if (req_half) ctl_q[DATA_W-1:HALF_W] <= wdata[HALF_W-1:0];
      else               ctl_q[HALF_W-1:0] <= wdata[HALF_W-1:0];
    end
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (do_read) begin
      if (!req_legacy)   rd_next = ctl_q;
      else if (req_half) rd_next[HALF_W-1:0] = ctl_q[DATA_W-1:HALF_W];
      else               rd_next[HALF_W-1:0] = ctl_q[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_kind       <= K_DIRECT;
      rsp_nomatch    <= 1'b0;
      rsp_write      <= 1'b0;
      rsp_rdata      <= '0;
      rsp_ec         <= '0;
      rsp_redir_addr <= '0;
      rsp_wdata      <= '0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_kind       <= claimed ? kind : K_DIRECT;
      rsp_nomatch    <= req_valid && !claimed;
      rsp_write      <= req_valid && req_write;
      rsp_rdata      <= rd_next;
      rsp_ec         <= (claimed && kind == K_TRAP) ? TRAP_EC : '0;
      rsp_redir_addr <= (claimed && kind == K_REDIR) ? slot_base + ADDR_W'(SLOT_OFF) : '0;
      rsp_wdata      <= (claimed && kind == K_REDIR && req_write) ? wdata : '0;
    end
  end

  p_el0_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (claimed && cur_el == 2'd0) |=> (rsp_kind == K_UNDEF));

  p_trap_ec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == K_TRAP) |-> (rsp_ec == 6'h18));

  p_redir_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_ok && !req_legacy && at_el1 && el2_live && !trap_acr && nv_hit)
      |=> (rsp_kind == K_REDIR && rsp_redir_addr == $past(slot_base) + ADDR_W'(SLOT_OFF)));

  p_trap_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_ok && !req_legacy && at_el1 && el2_live && trap_acr)
      |=> (rsp_kind == K_TRAP));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0 && !rsp_nomatch));
endmodule

// File: tb/test_sysreg_gate.sv
module test_sysreg_gate;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_legacy = 0, req_half = 0;
  logic [1:0] op0 = 2'b11; logic [2:0] op1 = 0; logic [3:0] crn = 1; logic [3:0] crm = 0; logic [2:0] op2 = 1;
  logic [63:0] wdata = 0;
  logic [1:0] cur_el = 0;
  logic el2_en = 0, el2_64 = 0, trap_acr = 0;
  logic [2:0] nv_bits = 0;
  logic [47:0] slot_base = 48'h1000;
  logic rsp_valid, rsp_nomatch, rsp_write;
  logic [1:0] rsp_kind;
  logic [63:0] rsp_rdata, rsp_wdata;
  logic [5:0] rsp_ec;
  logic [47:0] rsp_redir_addr;
  int checks = 0, errors = 0;
  logic [63:0] model;

  always #4 clk = ~clk;

  sysreg_gate i_sysreg_gate (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go(bit wr, bit leg, bit half, logic [1:0] el, logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_legacy = leg; req_half = half; cur_el = el; wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic read_full(string req, logic [63:0] exp);
    go(0, 0, 0, 2'd3, 0);
    chk({req, " kind"}, 64'(rsp_kind), 0);
    chk({req, " rdata"}, rsp_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R9 reset valid", 64'(rsp_valid), 0);
    chk("R9 reset kind", 64'(rsp_kind), 0);
  endtask

  task automatic t_direct;
    model = 64'hDEAD_BEEF_0123_4567;
    go(1, 0, 0, 2'd3, model);
    chk("R5 el3 write kind", 64'(rsp_kind), 0);
    chk("R9 valid pulse", 64'(rsp_valid), 1);
    chk("R9 write rdata zero", rsp_rdata, 0);
    @(negedge clk);
    chk("R9 single cycle", 64'(rsp_valid), 0);
    read_full("R5 el3 read", model);
    model = 64'h1111_2222_3333_4444;
    go(1, 0, 0, 2'd2, model);
    read_full("R5 el2 write", model);
    el2_en = 1; el2_64 = 1; trap_acr = 0; nv_bits = 3'b100;
    go(0, 0, 0, 2'd1, 0);
    chk("R5 el1 direct kind", 64'(rsp_kind), 0);
    chk("R5 el1 rdata", rsp_rdata, model);
    nv_bits = 3'b001;
    go(0, 0, 0, 2'd1, 0);
    chk("R4 nv 0x1 not redirect", 64'(rsp_kind), 0);
    nv_bits = 0;
  endtask

  task automatic t_el0;
    go(1, 0, 0, 2'd0, 64'hFFFF);
    chk("R2 el0 write kind", 64'(rsp_kind), 1);
    go(0, 1, 1, 2'd0, 0);
    chk("R2 el0 legacy kind", 64'(rsp_kind), 1);
    chk("R2 el0 rdata", rsp_rdata, 0);
    read_full("R2 no update", model);
  endtask

  task automatic t_trap;
    el2_en = 1; el2_64 = 1; trap_acr = 1; nv_bits = 3'b000;
    go(1, 0, 0, 2'd1, 64'h5);
    chk("R3 trap kind", 64'(rsp_kind), 2);
    chk("R3 trap ec", 64'(rsp_ec), 64'h18);
    nv_bits = 3'b101;
    go(0, 0, 0, 2'd1, 0);
    chk("R10 trap beats redirect", 64'(rsp_kind), 2);
    chk("R10 no redir addr", 64'(rsp_redir_addr), 0);
    read_full("R3 no update", model);
    chk("R3 ec zero on direct", 64'(rsp_ec), 0);
  endtask

  task automatic t_redir;
    el2_en = 1; el2_64 = 1; trap_acr = 0; nv_bits = 3'b111; slot_base = 48'h0000_8000_0000;
    go(1, 0, 0, 2'd1, 64'hABCD);
    chk("R4 redir kind", 64'(rsp_kind), 3);
    chk("R4 redir addr", 64'(rsp_redir_addr), 64'h8000_0118);
    chk("R4 redir wdata", rsp_wdata, 64'hABCD);
    chk("R4 redir rdata", rsp_rdata, 0);
    read_full("R4 no update", model);
  endtask

  task automatic t_gated;
    trap_acr = 1; nv_bits = 3'b101;
    el2_en = 0; el2_64 = 1;
    go(0, 0, 0, 2'd1, 0);
    chk("R6 el2 off kind", 64'(rsp_kind), 0);
    chk("R6 el2 off rdata", rsp_rdata, model);
    el2_en = 1; el2_64 = 0;
    model = 64'h7777_0000_0000_7777;
    go(1, 0, 0, 2'd1, model);
    chk("R6 el2 32bit kind", 64'(rsp_kind), 0);
    read_full("R6 write landed", model);
    el2_en = 0; trap_acr = 0; nv_bits = 0;
  endtask

  task automatic t_legacy;
    go(1, 1, 0, 2'd1, 64'hFFFF_FFFF_AAAA_5555);
    model[31:0] = 32'hAAAA_5555;
    read_full("R8 low half write", model);
    go(1, 1, 1, 2'd2, 64'h0000_0000_1234_5678);
    model[63:32] = 32'h1234_5678;
    read_full("R8 high half write", model);
    go(0, 1, 0, 2'd1, 0);
    chk("R7 low view", rsp_rdata, {32'h0, model[31:0]});
    go(0, 1, 1, 2'd3, 0);
    chk("R7 high view", rsp_rdata, {32'h0, model[63:32]});
    chk("R7 legacy kind", 64'(rsp_kind), 0);
  endtask

  task automatic t_nomatch;
    crm = 4'b0001;
    go(1, 0, 0, 2'd3, 64'h0);
    chk("R1 nomatch flag", 64'(rsp_nomatch), 1);
    chk("R1 nomatch kind", 64'(rsp_kind), 0);
    crm = 0; op2 = 3'b000;
    go(1, 0, 0, 2'd3, 64'h0);
    chk("R1 op2 nomatch", 64'(rsp_nomatch), 1);
    op2 = 3'b001;
    read_full("R1 no update", model);
    chk("R1 match clears flag", 64'(rsp_nomatch), 0);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_direct();
    t_el0();
    t_trap();
    t_redir();
    t_gated();
    t_legacy();
    t_nomatch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule